// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that lets a host controller write and read a bank of 8-bit configuration registers. A transaction is framed by an active-low chip select and carries exactly sixteen serial clock periods. The first eight bits form a control word: a direction flag followed by a 7-bit register address. The second eight bits are the data byte. On a write the host supplies it on the serial input. On a read the slave shifts the addressed register out on the serial output.

All serial pins are brought into the system clock domain through synchronizers, and the serial clock edges are detected there. Input bits are taken on serial clock falling edges and output bits are launched on rising edges. A mode pin decides who owns the configuration. While it is low, the host port is live. While it is high, the port ignores all traffic. The whole register bank is presented in parallel to the surrounding logic.

The block has no streaming data path. Every pin is a plain control or status signal, so no valid/ready handshake and no back-pressure apply.

Top module: `serreg_slave`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o` and `sdo` is low.
- R2: Bits travel most significant first. Bit 1 of a frame is the direction flag, bits 2 to 8 are address A6..A0, and bits 9 to 16 are data D7..D0. Register `a` occupies `regs_o[a*8 +: 8]`.
- R3: The serial input is taken only at falling edges of `sclk`. Its value while `sclk` is low has no effect.
- R4: With a flag of 0, the data byte is stored into the addressed register once the sixteenth bit is taken, as a single system-clock update. No other register changes.
- R5: With a flag of 1, the addressed register is captured after the last address bit. Its bits D7..D0 appear on `sdo`, each changing on the rising `sclk` edges that follow the eighth through fifteenth falling edges.
- R6: `sdo` is held low whenever chip select is high and whenever no read data phase is in progress.
- R7: If `cs_n` rises before sixteen bits have been taken, the frame is dropped. No register is written, and the next frame starts again at bit 1.
- R8: While `hw_mode` is high, serial frames are ignored: no register is written and `sdo` stays low.
- R9: Falling edges after the sixteenth within one chip-select window are ignored. The register keeps the first data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | High: the serial port is disabled; low: host access is enabled |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host, low when idle |
| regs_o | output | 1024 | Parallel contents of all 128 registers |

## Verification
On every cycle, the assertions check these properties: the bit counter returns to zero whenever the port is inactive, a write fires only once the counter has reached sixteen and never in hardware mode, the write strobe lasts one cycle, a strobed byte lands in the addressed register, and the output is driven low while inactive. Some behaviours can only be shown by the bench's scenarios, because they depend on the whole frame. These are the bit ordering, the read data timing relative to serial clock edges, immunity to input changes while the serial clock is low, the dropping of short frames, and the ignoring of surplus clocks.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int unsigned ADDR_W_DEF  = 7;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam int unsigned SYNC_N_DEF  = 2;
  // index of each synchronised input within the synchroniser vector
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_CSN  = 1;
  localparam int unsigned IDX_SDI  = 2;
  localparam int unsigned IDX_HW   = 3;
  localparam int unsigned NUM_SYNC = 4;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic              hw_s,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam int unsigned CTRL_BITS = 1 + ADDR_W;
  localparam int unsigned FRAME     = CTRL_BITS + DATA_W;
  localparam int unsigned CNT_W     = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CTRL_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME);

  logic              sclk_d;
  logic              fall, rise, active;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAME-1:0]  sh_q;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_sh_q;
  logic              rd_act_q;

  assign fall   = sclk_d & ~sclk_s;
  assign rise   = ~sclk_d & sclk_s;
  assign active = ~cs_n_s & ~hw_s;

  // address as it stands once the last control bit arrives
  assign raddr_o = {sh_q[ADDR_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      rd_sh_q   <= '0;
      rd_act_q  <= 1'b0;
      sdo_o     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (!active) begin
      cnt_q    <= '0;
      rd_act_q <= 1'b0;
      sdo_o    <= 1'b0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (fall && cnt_q < FULL) begin
        sh_q  <= {sh_q[FRAME-2:0], sdi_s};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_CTRL) begin
          rw_q   <= sh_q[ADDR_W-1];
          addr_q <= raddr_o;
          if (sh_q[ADDR_W-1]) begin
            rd_sh_q  <= rdata_i;
            rd_act_q <= 1'b1;
          end
        end
        if (cnt_q == LAST_BIT && !rw_q) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= addr_q;
          wr_data_o <= {sh_q[DATA_W-2:0], sdi_s};
        end
      end
      if (rise && rd_act_q) begin
        sdo_o   <= rd_sh_q[DATA_W-1];
        rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_q == '0);  // R7
  AST_WR_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> cnt_q == FULL);  // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);  // R4
  AST_NO_WR_HW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !$past(hw_s));  // R8
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo_o);  // R6
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);  // R9
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             raddr_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [(2**ADDR_W)*DATA_W-1:0] regs_o
);
  localparam int unsigned NUM_REGS = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) mem_q[i] <= wr_data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign rdata_o = mem_q[raddr_i];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));  // R4
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
  import serreg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hw_mode,
  input  logic                          cs_n,
  input  logic                          sclk,
  input  logic                          sdi,
  output logic                          sdo,
  output logic [(2**ADDR_W)*DATA_W-1:0] regs_o
);
  localparam logic [NUM_SYNC-1:0] SYNC_RST = NUM_SYNC'(4'b1011);

  logic [NUM_SYNC-1:0] raw, syn;
  logic [ADDR_W-1:0]   raddr, wr_addr;
  logic [DATA_W-1:0]   rdata, wr_data;
  logic                wr_en;

  always_comb begin
    raw           = '0;
    raw[IDX_SCLK] = sclk;
    raw[IDX_CSN]  = cs_n;
    raw[IDX_SDI]  = sdi;
    raw[IDX_HW]   = hw_mode;
  end

  serreg_sync #(.STAGES(SYNC_N), .W(NUM_SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  serreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(syn[IDX_SCLK]), .cs_n_s(syn[IDX_CSN]),
    .sdi_s(syn[IDX_SDI]), .hw_s(syn[IDX_HW]),
    .rdata_i(rdata), .raddr_o(raddr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdo_o(sdo)
  );

  serreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .raddr_i(raddr), .rdata_o(rdata), .regs_o(regs_o)
  );
endmodule

// File: tb/test_serreg_slave.sv
`timescale 1ns/1ps
module test_serreg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  logic [1023:0] regs_o;

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  serreg_slave i_serreg_slave (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .regs_o(regs_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] reg_at(int a);
    return regs_o[a*8 +: 8];
  endfunction

  // one chip-select window; garbage is placed on sdi while sclk is low (R3)
  task automatic frame(input logic rw, input logic [6:0] addr,
                       input logic [7:0] data, input int nbits,
                       output logic [7:0] got);
    logic [15:0] vec;
    vec = {rw, addr, data};
    got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    waitc(HALF);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? vec[15-i] : 1'b1;
      sdi = b;
      waitc(HALF);
      sclk = 1'b0;
      waitc(2);
      sdi = ~b;
      waitc(HALF-2);
      sclk = 1'b1;
      waitc(HALF);
      if (rw && i >= 7 && i <= 14) got[14-i] = sdo;
      if (!rw && i < 16) check("R6 sdo low in write frame", sdo, 1'b0);
    end
    waitc(HALF);
    cs_n = 1'b1;
    waitc(4*HALF);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] g;
    frame(1'b0, a, d, 16, g);
  endtask

  task automatic rd_sb(input logic [6:0] a, input logic [7:0] e);
    logic [7:0] g;
    exp_q.push_back(e);
    frame(1'b1, a, 8'h00, 16, g);
    got_q.push_back(g);
  endtask

  // monitor: compares serial read results against the expected queue (R5)
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        check("R5 read data", g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] g;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R1
    check("R1 sdo after reset", sdo, 1'b0);
    check("R1 regs after reset", {31'b0, |regs_o}, 32'd0);
    hw_mode = 1'b0;
    waitc(6);

    // R4 / R2 writes at edge and middle addresses
    wr(7'd0, 8'hA5);    check("R4 reg0", reg_at(0), 8'hA5);
    wr(7'd127, 8'h3C);  check("R2 reg127", reg_at(127), 8'h3C);
    wr(7'd5, 8'h81);    check("R2 reg5", reg_at(5), 8'h81);
    wr(7'd64, 8'hFF);   check("R4 reg64", reg_at(64), 8'hFF);
    check("R4 neighbour 63 untouched", reg_at(63), 8'h00);
    check("R4 neighbour 65 untouched", reg_at(65), 8'h00);

    // R3: sdi toggled while sclk low on every bit
    wr(7'h2A, 8'h55);   check("R3 fall-only sampling", reg_at(42), 8'h55);

    // R5 reads through scoreboard
    rd_sb(7'd127, 8'h3C);
    rd_sb(7'd0, 8'hA5);
    rd_sb(7'd5, 8'h81);
    rd_sb(7'd64, 8'hFF);
    rd_sb(7'd10, 8'h00);
    rd_sb(7'h2A, 8'h55);
    check("R6 sdo low after read", sdo, 1'b0);

    // R7 short frame
    frame(1'b0, 7'd9, 8'hEE, 12, g);
    check("R7 short frame no write", reg_at(9), 8'h00);
    wr(7'd9, 8'h12);
    check("R7 next frame starts fresh", reg_at(9), 8'h12);

    // R8 hardware mode
    hw_mode = 1'b1;
    waitc(6);
    wr(7'd5, 8'h00);
    check("R8 write ignored", reg_at(5), 8'h81);
    frame(1'b1, 7'd5, 8'h00, 16, g);
    check("R8 sdo stays low on read", g, 8'h00);
    hw_mode = 1'b0;
    waitc(6);

    // R9 surplus clocks
    frame(1'b0, 7'd3, 8'hC7, 20, g);
    check("R9 extra bits ignored", reg_at(3), 8'hC7);
    check("R9 reg4 untouched", reg_at(4), 8'h00);
    wr(7'd3, 8'h6E);
    check("R9 port usable after", reg_at(3), 8'h6E);
    rd_sb(7'd3, 8'h6E);

    waitc(20);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule